// File: doc/BRIEF.md
# Host FIFO to JTAG Bridge

This block connects an 8-bit asynchronous host FIFO, such as the parallel side of a USB bridge chip, to a JTAG target and to the two enable lines of a serial configuration device. It pulls one byte at a time from the FIFO through a three-state loop: wait for data, fetch, apply. Each byte is then used in one of two ways. A byte with its top bit clear is a pin command. It sets TCK, TMS, TDI, the two configuration enables and an indicator LED directly, and it can ask for TDO and the configuration status to be sent back to the host. A byte with its top bit set is a run header. The data bytes that follow it are serialized LSB-first onto TDI with eight generated TCK pulses each. The captured TDO bits can be returned to the host, one byte per data byte.

TDI only changes while TCK is low or at a falling edge, and TDO is captured at the rising edge. The high and low phases of TCK last at least `HALF_CYCLES` clocks each. With the default of 2, a 24 MHz clock gives a TCK of 6 MHz, which slow targets accept.

Top module: `usb_jtag_bridge`

## Requirements
- R1: After reset, `jtag_tck`, `jtag_tms`, `jtag_tdi` and `led` are low, `cfg_en_n` and `cfg_sel_n` are high, `host_rd_n` is high and `host_wr` is low. No run is pending, so the first byte fetched is treated as a command.
- R2: While `host_rx_ready_n` is low in the wait state, `host_rd_n` goes low for exactly one cycle, starting one cycle after the flag is seen. The byte is latched at the end of that cycle. The pin levels of a command appear three cycles after the cycle in which `host_rx_ready_n` went low.
- R3: A pin command (bit 7 = 0) sets the lines from these bits: bit 0 TCK, bit 1 TMS, bit 2 `cfg_en_n`, bit 3 `cfg_sel_n`, bit 4 TDI, bit 5 LED. The levels hold until the next pin command.
- R4: A pin command with bit 6 set writes one byte `{6'b0, cfg_status_n, jtag_tdo}` to the host before the next byte is fetched. In the default case, where the host can accept the byte, `host_wr` rises one cycle after the pin levels change.
- R5: A byte with bit 7 = 1 is a run header. Bits 5..0 give the number of data bytes that follow (0 to 63), and bit 6 requests read-back. With a count of 0, the next byte is a command again.
- R6: Each data byte of a run produces exactly eight TCK pulses. TDI carries the byte LSB-first. TDI changes only while TCK is low or as TCK falls, and never while TCK stays high.
- R7: When the run requested read-back, each data byte sends one byte to the host holding the TDO bits captured at the eight rising edges, with the first in bit 0. Without the request, nothing is written.
- R8: `host_wr` is a single-cycle pulse, issued only in a cycle after `host_tx_ready_n` was seen low. While the host cannot accept data the block waits, and it loses no byte and fetches nothing.
- R9: Every high phase and every low phase of `jtag_tck` lasts at least `HALF_CYCLES` clock cycles. During a run, one bit takes exactly 2*`HALF_CYCLES` clock cycles.
- R10: A header drives the pin-command TCK level low. After a run, TCK is low and TDI, TMS, the enables and the LED are at the levels of the last pin command.
- R11: A reset in the middle of a run abandons the remaining count, so the next byte fetched after reset is taken as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rx_ready_n | input | 1 | Low when the host FIFO holds a byte to read |
| host_tx_ready_n | input | 1 | Low when the host FIFO can accept a byte |
| host_rd_n | output | 1 | Active-low read strobe |
| host_wr | output | 1 | Write strobe, one cycle per byte |
| host_din | input | 8 | Byte read from the host FIFO |
| host_dout | output | 8 | Byte written to the host FIFO |
| jtag_tck | output | 1 | JTAG test clock |
| jtag_tms | output | 1 | JTAG mode select |
| jtag_tdi | output | 1 | JTAG data to the target |
| jtag_tdo | input | 1 | JTAG data from the target |
| cfg_en_n | output | 1 | Configuration device enable, active low |
| cfg_sel_n | output | 1 | Configuration device select, active low |
| cfg_status_n | input | 1 | Configuration status flag returned on read-back |
| led | output | 1 | Indicator output |

## Verification
The read strobe is due one cycle after the ready flag falls, and the new pin levels two cycles after that. A read-back write follows one cycle later if the host can accept it. A directed test counts falling clock edges from the ready flag to each of these events and compares the counts exactly. During a run, bits are 2*`HALF_CYCLES` clocks apart. The bench does not predict cycle numbers for random traffic. Instead, it records TDI at every observed TCK rise and every byte written to the host, and compares these streams with streams its own model predicts from the command bytes. TDO comes from a function of the number of rises so far, so every captured bit can be predicted. All outputs are sampled on the falling clock edge, and drain waits are bounded by the number of expected items, not by a fixed cycle count.

// File: rtl/ujb_pkg.sv
package ujb_pkg;

    localparam int CNT_W   = 6;
    localparam int B_TCK   = 0;
    localparam int B_TMS   = 1;
    localparam int B_EN    = 2;
    localparam int B_SEL   = 3;
    localparam int B_TDI   = 4;
    localparam int B_LED   = 5;
    localparam int B_RBACK = 6;
    localparam int B_HDR   = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GETCMD,
        ST_USECMD,
        ST_SHIFT,
        ST_WRITE
    } ctl_state_e;

    typedef struct packed {
        logic tck;
        logic tms;
        logic en_n;
        logic sel_n;
        logic tdi;
        logic led;
    } pin_set_t;

    localparam pin_set_t PINS_RESET = '{tck: 1'b0, tms: 1'b0, en_n: 1'b1,
                                        sel_n: 1'b1, tdi: 1'b0, led: 1'b0};

    typedef struct packed {
        ctl_state_e       st;
        logic             rd_n;
        logic             wr;
        logic [7:0]       dout;
        logic [7:0]       cmd;
        logic [CNT_W-1:0] left;
        logic             rback;
        logic             keep;
        pin_set_t         pins;
    } ctl_reg_t;

    function automatic pin_set_t decode_pins(input logic [7:0] c);
        pin_set_t p;
        p.tck   = c[B_TCK];
        p.tms   = c[B_TMS];
        p.en_n  = c[B_EN];
        p.sel_n = c[B_SEL];
        p.tdi   = c[B_TDI];
        p.led   = c[B_LED];
        return p;
    endfunction

endpackage

// File: rtl/ujb_shifter.sv
module ujb_shifter #(
    parameter int HALF_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] byte_in,
    input  logic       tdo,
    output logic       active,
    output logic       tck,
    output logic       tdi,
    output logic       done,
    output logic [7:0] cap
);
    localparam int PH_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam int HD_W = $clog2(HALF_CYCLES + 1) + 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_CYCLES - 1);

    typedef struct packed {
        logic            active;
        logic            tck;
        logic            tdi;
        logic            hi;
        logic [PH_W-1:0] ph;
        logic [2:0]      bitn;
        logic [7:0]      data;
        logic [7:0]      cap;
    } sh_reg_t;

    sh_reg_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (start) begin
            d.active = 1'b1;
            d.tck    = 1'b0;
            d.tdi    = byte_in[0];
            d.data   = byte_in;
            d.ph     = '0;
            d.hi     = 1'b0;
            d.bitn   = 3'd0;
        end else if (q.active) begin
            if (q.ph == PH_LAST) begin
                d.ph = '0;
                if (!q.hi) begin
                    d.tck = 1'b1;
                    d.hi  = 1'b1;
                    d.cap = {tdo, q.cap[7:1]};
                end else begin
                    d.tck = 1'b0;
                    d.hi  = 1'b0;
                    if (q.bitn == 3'd7) begin
                        d.active = 1'b0;
                        done     = 1'b1;
                    end else begin
                        d.bitn = q.bitn + 3'd1;
                        d.tdi  = q.data[q.bitn + 3'd1];
                    end
                end
            end else begin
                d.ph = q.ph + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active = q.active;
    assign tck    = q.tck;
    assign tdi    = q.tdi;
    assign cap    = q.cap;

    // Checker state: level duration and rise count, kept apart from the datapath
    logic [HD_W-1:0] hold_q;
    logic            tck_prev_q;
    logic [3:0]      rises_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= '0;
            tck_prev_q <= 1'b0;
            rises_q    <= '0;
        end else begin
            tck_prev_q <= q.tck;
            if (q.tck != tck_prev_q) hold_q <= '0;
            else if (hold_q < HD_W'(HALF_CYCLES)) hold_q <= hold_q + HD_W'(1);
            if (start) rises_q <= '0;
            else if (q.tck && !tck_prev_q) rises_q <= rises_q + 4'd1;
        end
    end

    p_tck_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_prev_q != $past(tck_prev_q)) |-> ($past(hold_q) >= HD_W'(HALF_CYCLES - 1)))
        else $error("TCK level shorter than the minimum half period");

    p_tdi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.tck && $past(q.tck)) |-> $stable(q.tdi))
        else $error("TDI moved while TCK was high");

    p_eight_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rises_q + 4'(q.tck && !tck_prev_q)) == 4'd8))
        else $error("data byte did not give eight TCK pulses");

endmodule

// File: rtl/ujb_ctrl.sv
module ujb_ctrl
    import ujb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_ready_n,
    input  logic       tx_ready_n,
    input  logic [7:0] din,
    output logic       rd_n,
    output logic       wr,
    output logic [7:0] dout,
    input  logic       tdo,
    input  logic       status_n,
    input  logic       sh_done,
    input  logic [7:0] sh_cap,
    output logic       sh_start,
    output logic [7:0] sh_byte,
    output pin_set_t   pins
);
    ctl_reg_t q, d;

    always_comb begin
        d        = q;
        d.rd_n   = 1'b1;
        d.wr     = 1'b0;
        sh_start = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (!rx_ready_n) begin
                    d.rd_n = 1'b0;
                    d.st   = ST_GETCMD;
                end
            end
            ST_GETCMD: begin
                d.cmd = din;
                d.st  = ST_USECMD;
            end
            ST_USECMD: begin
                if (q.left != '0) begin
                    sh_start = 1'b1;
                    d.st     = ST_SHIFT;
                end else if (q.cmd[B_HDR]) begin
                    d.left     = q.cmd[CNT_W-1:0];
                    d.rback    = q.cmd[B_RBACK];
                    d.pins.tck = 1'b0;
                    d.st       = ST_IDLE;
                end else begin
                    d.pins = decode_pins(q.cmd);
                    d.keep = 1'b0;
                    d.st   = q.cmd[B_RBACK] ? ST_WRITE : ST_IDLE;
                end
            end
            ST_SHIFT: begin
                if (sh_done) begin
                    d.left = q.left - CNT_W'(1);
                    if (q.rback) begin
                        d.dout = sh_cap;
                        d.keep = 1'b1;
                        d.st   = ST_WRITE;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_WRITE: begin
                if (!tx_ready_n) begin
                    d.wr = 1'b1;
                    if (!q.keep) d.dout = {6'b0, status_n, tdo};
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, rd_n: 1'b1, wr: 1'b0, dout: 8'h00, cmd: 8'h00,
                   left: '0, rback: 1'b0, keep: 1'b0, pins: PINS_RESET};
        end else begin
            q <= d;
        end
    end

    assign rd_n    = q.rd_n;
    assign wr      = q.wr;
    assign dout    = q.dout;
    assign pins    = q.pins;
    assign sh_byte = q.cmd;

    p_rd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !q.rd_n |=> q.rd_n)
        else $error("read strobe longer than one cycle");

    p_rd_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rd_n) |-> $past(!rx_ready_n))
        else $error("read strobe without data available");

    p_wr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr)
        else $error("write strobe longer than one cycle");

    p_wr_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> $past(!tx_ready_n))
        else $error("write strobe while the host FIFO was full");

endmodule

// File: rtl/usb_jtag_bridge.sv
module usb_jtag_bridge
    import ujb_pkg::*;
#(
    parameter int HALF_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_rx_ready_n,
    input  logic       host_tx_ready_n,
    output logic       host_rd_n,
    output logic       host_wr,
    input  logic [7:0] host_din,
    output logic [7:0] host_dout,
    output logic       jtag_tck,
    output logic       jtag_tms,
    output logic       jtag_tdi,
    input  logic       jtag_tdo,
    output logic       cfg_en_n,
    output logic       cfg_sel_n,
    input  logic       cfg_status_n,
    output logic       led
);
    pin_set_t   pins;
    logic       sh_start, sh_done, sh_active, sh_tck, sh_tdi;
    logic [7:0] sh_byte, sh_cap;

    ujb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_ready_n (host_rx_ready_n),
        .tx_ready_n (host_tx_ready_n),
        .din        (host_din),
        .rd_n       (host_rd_n),
        .wr         (host_wr),
        .dout       (host_dout),
        .tdo        (jtag_tdo),
        .status_n   (cfg_status_n),
        .sh_done    (sh_done),
        .sh_cap     (sh_cap),
        .sh_start   (sh_start),
        .sh_byte    (sh_byte),
        .pins       (pins)
    );

    ujb_shifter #(.HALF_CYCLES(HALF_CYCLES)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .byte_in (sh_byte),
        .tdo     (jtag_tdo),
        .active  (sh_active),
        .tck     (sh_tck),
        .tdi     (sh_tdi),
        .done    (sh_done),
        .cap     (sh_cap)
    );

    assign jtag_tck  = sh_active ? sh_tck : pins.tck;
    assign jtag_tdi  = sh_active ? sh_tdi : pins.tdi;
    assign jtag_tms  = pins.tms;
    assign cfg_en_n  = pins.en_n;
    assign cfg_sel_n = pins.sel_n;
    assign led       = pins.led;

endmodule

// File: tb/tb_usb_jtag_bridge.sv
module tb_usb_jtag_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_rx_ready_n = 1'b1;
    logic host_tx_ready_n = 1'b0;
    logic host_rd_n, host_wr;
    logic [7:0] host_din = 8'h00;
    logic [7:0] host_dout;
    logic jtag_tck, jtag_tms, jtag_tdi;
    logic jtag_tdo = 1'b0;
    logic cfg_en_n, cfg_sel_n, led;
    logic cfg_status_n = 1'b1;

    usb_jtag_bridge #(.HALF_CYCLES(HALF)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_rx_ready_n(host_rx_ready_n), .host_tx_ready_n(host_tx_ready_n),
        .host_rd_n(host_rd_n), .host_wr(host_wr),
        .host_din(host_din), .host_dout(host_dout),
        .jtag_tck(jtag_tck), .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi), .jtag_tdo(jtag_tdo),
        .cfg_en_n(cfg_en_n), .cfg_sel_n(cfg_sel_n), .cfg_status_n(cfg_status_n), .led(led)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [7:0] hostq[$];
    logic [7:0] exp_rx[$];
    logic [7:0] obs_rx[$];
    string      exp_rx_tag[$];
    logic       exp_tdi[$];
    logic       obs_tdi[$];
    string      exp_tdi_tag[$];

    // bench model of the command stream
    int   m_left = 0;
    bit   m_rb = 0;
    logic m_tck = 0, m_tms = 0, m_en = 1, m_sel = 1, m_tdi = 0, m_led = 0;
    int   m_rises = 0;
    logic m_status = 1;

    // monitor state
    int   neg_cnt = 0, rises = 0, run = 1, rd_lows = 0, pops = 0;
    int   t_rxf_fall = 0, t_line = 0, t_wr = 0;
    bit   prev_rd_low = 0;
    logic prev_tck = 0, prev_tdi = 0;
    logic [3:0] prev_lines = 4'b0110;
    int   txe_mode = 0;

    function automatic logic tdo_bit(input int k);
        return logic'(((k * 29 + 7) >> 3) & 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_left = 0; m_rb = 0; m_tck = 0; m_tms = 0; m_en = 1; m_sel = 1;
        m_tdi = 0; m_led = 0; m_rises = 0;
        exp_rx.delete(); exp_rx_tag.delete(); exp_tdi.delete(); exp_tdi_tag.delete();
    endtask

    task automatic push(input logic [7:0] b);
        if (m_left > 0) begin
            logic [7:0] c = 8'h00;
            for (int i = 0; i < 8; i++) begin
                exp_tdi.push_back(b[i]);
                exp_tdi_tag.push_back("R6");
                c[i] = tdo_bit(m_rises + i);
            end
            m_rises += 8;
            if (m_rb) begin
                exp_rx.push_back(c);
                exp_rx_tag.push_back("R7");
            end
            m_left--;
            m_tck = 0;
        end else if (b[7]) begin
            m_left = int'(b[5:0]);
            m_rb   = b[6];
            m_tck  = 0;
        end else begin
            if (b[0] && !m_tck) begin
                m_rises++;
                exp_tdi.push_back(b[4]);
                exp_tdi_tag.push_back("R3");
            end
            m_tck = b[0]; m_tms = b[1]; m_en = b[2]; m_sel = b[3]; m_tdi = b[4]; m_led = b[5];
            if (b[6]) begin
                exp_rx.push_back({6'b0, m_status, tdo_bit(m_rises)});
                exp_rx_tag.push_back("R4");
            end
        end
        hostq.push_back(b);
    endtask

    // host FIFO and pin monitor, all on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            neg_cnt++;
            if (!rst_n) begin
                hostq.delete(); obs_rx.delete(); obs_tdi.delete();
                rises = 0; run = 1; prev_rd_low = 0; prev_tck = 0; prev_tdi = 0;
                prev_lines = 4'b0110; rd_lows = 0; pops = 0;
                host_rx_ready_n = 1'b1; host_din = 8'h00; jtag_tdo = tdo_bit(0);
            end else begin
                logic old_rdy;
                if (prev_rd_low) begin
                    if (hostq.size() != 0) void'(hostq.pop_front());
                    pops++;
                end
                prev_rd_low = (host_rd_n == 1'b0);
                if (prev_rd_low) rd_lows++;
                old_rdy = host_rx_ready_n;
                host_rx_ready_n = (hostq.size() == 0);
                host_din = (hostq.size() != 0) ? hostq[0] : 8'h00;
                if (old_rdy && !host_rx_ready_n) t_rxf_fall = neg_cnt;
                if (host_wr) begin
                    obs_rx.push_back(host_dout);
                    t_wr = neg_cnt;
                end
                if (jtag_tck != prev_tck) begin
                    chk(run >= HALF, "R9 tck phase", run, HALF);
                    if (jtag_tck) begin
                        obs_tdi.push_back(jtag_tdi);
                        rises++;
                    end
                    run = 1;
                end else begin
                    run++;
                end
                if (prev_tck && jtag_tck && (jtag_tdi != prev_tdi))
                    chk(1'b0, "R6 tdi moved while tck high", int'(jtag_tdi), int'(prev_tdi));
                if ({jtag_tms, cfg_en_n, cfg_sel_n, led} != prev_lines) t_line = neg_cnt;
                prev_lines = {jtag_tms, cfg_en_n, cfg_sel_n, led};
                prev_tck = jtag_tck;
                prev_tdi = jtag_tdi;
                jtag_tdo = tdo_bit(rises);
            end
            host_tx_ready_n = (txe_mode == 2) ? 1'b1 :
                              (txe_mode == 1) ? (($urandom % 10) < 3) : 1'b0;
        end
    end

    task automatic finish_seg(input string tag);
        int guard = 0;
        while ((hostq.size() != 0 || obs_rx.size() < exp_rx.size() ||
                obs_tdi.size() < exp_tdi.size()) && guard < 20000) begin
            @(posedge clk);
            guard++;
        end
        repeat (80) @(posedge clk);
        #1;
        chk(obs_rx.size() == exp_rx.size(), {tag, " R7 host byte count"}, obs_rx.size(), exp_rx.size());
        for (int i = 0; i < exp_rx.size() && i < obs_rx.size(); i++)
            chk(obs_rx[i] == exp_rx[i], {tag, " ", exp_rx_tag[i], " host byte"}, obs_rx[i], exp_rx[i]);
        chk(obs_tdi.size() == exp_tdi.size(), {tag, " R6 tck rise count"}, obs_tdi.size(), exp_tdi.size());
        for (int i = 0; i < exp_tdi.size() && i < obs_tdi.size(); i++)
            chk(obs_tdi[i] == exp_tdi[i], {tag, " ", exp_tdi_tag[i], " tdi at rise"}, obs_tdi[i], exp_tdi[i]);
        chk(jtag_tms == m_tms, {tag, " R3 tms"}, jtag_tms, m_tms);
        chk(cfg_en_n == m_en, {tag, " R3 en_n"}, cfg_en_n, m_en);
        chk(cfg_sel_n == m_sel, {tag, " R3 sel_n"}, cfg_sel_n, m_sel);
        chk(led == m_led, {tag, " R3 led"}, led, m_led);
        chk(jtag_tck == m_tck, {tag, " R10 tck level"}, jtag_tck, m_tck);
        chk(jtag_tdi == m_tdi, {tag, " R10 tdi level"}, jtag_tdi, m_tdi);
        chk(rd_lows == pops, {tag, " R2 read strobes vs bytes taken"}, rd_lows, pops);
        obs_rx.delete(); obs_tdi.delete();
        exp_rx.delete(); exp_rx_tag.delete(); exp_tdi.delete(); exp_tdi_tag.delete();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset levels
        chk(jtag_tck == 0 && jtag_tms == 0 && jtag_tdi == 0, "R1 jtag lines", {jtag_tck, jtag_tms, jtag_tdi}, 0);
        chk(cfg_en_n == 1 && cfg_sel_n == 1 && led == 0, "R1 cfg lines", {cfg_en_n, cfg_sel_n, led}, 6);
        chk(host_rd_n == 1 && host_wr == 0, "R1 strobes", {host_rd_n, host_wr}, 2);

        // R2, R4: exact timing of one pin command with read-back
        push(8'h60);
        repeat (20) @(posedge clk); #1;
        chk(t_line - t_rxf_fall == 3, "R2 pin latency", t_line - t_rxf_fall, 3);
        chk(t_wr - t_rxf_fall == 4, "R4 write latency", t_wr - t_rxf_fall, 4);
        finish_seg("directed-timing");

        // R5, R7: longest run with read-back
        push(8'hFF);
        for (int i = 0; i < 63; i++) push(8'($urandom));
        finish_seg("max-run");

        // R5: zero count header, next byte is a command
        push(8'hC0);
        push(8'h2A);
        finish_seg("zero-count");

        // R7: run without read-back writes nothing
        push(8'h82);
        push(8'h5A);
        push(8'hC3);
        push(8'h00);
        finish_seg("no-readback");

        // R8 / R4: host cannot accept, nothing more is fetched
        txe_mode = 2;
        push(8'h41);
        push(8'h20);
        repeat (60) @(posedge clk); #1;
        chk(obs_rx.size() == 0, "R8 no write while full", obs_rx.size(), 0);
        chk(hostq.size() == 1, "R4 next command held back", hostq.size(), 1);
        txe_mode = 0;
        finish_seg("stall");

        // random traffic with host back-pressure
        txe_mode = 1;
        for (int seg = 0; seg < 6; seg++) begin
            m_status = logic'($urandom % 2);
            cfg_status_n = m_status;
            for (int k = 0; k < 50; k++) begin
                if (($urandom % 100) < 65) begin
                    logic [7:0] b = 8'($urandom);
                    b[7] = 1'b0;
                    if (b[4] != m_tdi) b[0] = 1'b0;
                    push(b);
                end else begin
                    int cnt = $urandom % 5;
                    push({1'b1, 1'($urandom), 6'(cnt)});
                    for (int j = 0; j < cnt; j++) push(8'($urandom));
                end
            end
            finish_seg("random");
        end
        txe_mode = 0;

        // R11: reset in the middle of a run
        push(8'h83);
        push(8'hA5);
        push(8'h3C);
        push(8'h99);
        repeat (14) @(posedge clk); #1;
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        push(8'h20);
        finish_seg("reset-mid-run");
        chk(led == 1'b1, "R11 byte after reset is a command", led, 1);

        summary();
    end
endmodule